// File: doc/BRIEF.md
# Booth-Encoded Carry-Save Multiply-Accumulator

This block multiplies two signed operands on every accepted cycle and adds the product into a running total. The multiplier operand is recoded into radix-4 Booth digits, with one partial product per pair of multiplier bits. A negative digit produces its partial product by plain bit inversion of the selected multiple. The missing +1 for each such digit enters the adder tree as a single correction bit placed at that partial product's lowest position.

All partial products, a constant sign-extension vector, the correction bits and the stored running total are reduced together by a tree of 3:2 carry-save adders. The running total is kept in redundant form, as a sum vector and a carry vector, and is fed back into the same tree. Each accumulation step therefore has no carry-propagate path. The lowest bits of the tree output are resolved at once by a chain of 2-bit lookahead adders, so only the upper bits reach the final adder. That final adder turns the stored state into the visible accumulator value.

A host drives a pair of operands with a valid strobe, pulses clear to start a new sum, and reads the resolved total on the cycle after the last accepted pair.

Top module: `booth_csa_mac`

## Requirements
- R1: On a clock edge where validIn is 1 and clear is 0, the stored total becomes the previous total plus the signed product opA × opB, and accOut shows the new total right after that edge.
- R2: On a clock edge where validIn and clear are both 0, accOut keeps its value and the operand inputs have no effect.
- R3: On a clock edge where clear is 1, accOut becomes 0 right after that edge, whatever validIn and the operands are. Clear takes priority over validIn.
- R4: On a clock edge where rst is 1, accOut becomes 0 right after that edge. This synchronous reset takes priority over clear and validIn.
- R5: Each 3-bit group (b[2i+1], b[2i], b[2i-1]) of the multiplier opB, with b[-1] = 0, selects a digit: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives −2, 101 and 110 give −1. The products of corner operands (−32768 × −32768 = 2^30, −1 × −1, 0 × x) come out exact.
- R6: The total is a 40-bit two's-complement value that wraps modulo 2^40 on overflow.
- R7: The lowest 8 bits of the total are resolved inside the accumulation step. A carry out of those low bits still reaches the upper bits correctly (for example, 255 followed by 1 gives 256).
- R8: Negative products are sign-extended across all 40 bits (for example, −1 × 1 from zero gives all ones).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Zeroes the running total on the next edge |
| validIn | input | 1 | Accepts opA and opB on this edge |
| opA | input | 16 | Multiplicand, signed two's complement |
| opB | input | 16 | Multiplier, signed two's complement, Booth recoded |
| accOut | output | 40 | Resolved running total, signed two's complement |

## Verification
The bench builds the block with its default parameters: 16-bit operands, a 40-bit total and 8 early-resolved low bits. With these values the largest product is 2^30, so about 512 repeated products of −32768 × −32768 carry the total past 2^39 and into wraparound. That puts R6 within reach of a short run. The 8-bit low field is narrow enough that small hand-picked operands cross it and exercise the carry handed from the low resolver to the upper adder. Random operand streams with random holds and clears cover every Booth digit code in every digit position.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // accept the current operand pair
    logic zero;   // empty the running total
  } mac_strobe_t;

  // One recoded multiplier digit
  typedef struct packed {
    logic neg;    // negative selection (inverted multiple)
    logic two;    // magnitude two
    logic one;    // magnitude one
  } booth_digit_t;

  // Number of 3:2 levels needed to bring n operands down to two
  function automatic int treeLevels(input int n);
    int lv;
    int c;
    lv = 0;
    c = n;
    while (c > 2) begin
      c = (c / 3) * 2 + (c % 3);
      lv++;
    end
    return lv;
  endfunction

endpackage

// File: rtl/mac_cla2.sv
module mac_cla2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic       cin,
  output logic [1:0] sum,
  output logic       cout
);
  logic [1:0] gen;
  logic [1:0] prop;
  logic       c1;

  assign gen  = a & b;
  assign prop = a ^ b;
  // both carries come straight from generate/propagate terms
  assign c1   = gen[0] | (prop[0] & cin);
  assign cout = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & cin);
  assign sum  = {prop[1] ^ c1, prop[0] ^ cin};
endmodule

// File: rtl/mac_booth_pp.sv
module mac_booth_pp
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [OP_W-1:0]                   mcand,
  input  logic [OP_W-1:0]                   mplier,
  output logic [OP_W/2-1:0][ACC_W-1:0]      ppVec,
  output logic [ACC_W-1:0]                  corrVec
);
  localparam int NPP = OP_W / 2;
  localparam int PPW = OP_W + 1;

  logic [OP_W:0]   mplierExt;
  logic [NPP-1:0]  negBits;

  assign mplierExt = {mplier, 1'b0};

  genvar i;
  generate
    for (i = 0; i < NPP; i++) begin : g_pp
      booth_digit_t   dig;
      logic [PPW-1:0] mult;
      logic [PPW-1:0] pp;
      int             digVal;

      always_comb begin
        case (mplierExt[2*i+2 -: 3])
          3'b001, 3'b010: dig = '{neg: 1'b0, two: 1'b0, one: 1'b1};
          3'b011:         dig = '{neg: 1'b0, two: 1'b1, one: 1'b0};
          3'b100:         dig = '{neg: 1'b1, two: 1'b1, one: 1'b0};
          3'b101, 3'b110: dig = '{neg: 1'b1, two: 1'b0, one: 1'b1};
          default:        dig = '{neg: 1'b0, two: 1'b0, one: 1'b0};
        endcase
      end

      always_comb begin
        if (dig.two)      mult = {mcand, 1'b0};
        else if (dig.one) mult = {mcand[OP_W-1], mcand};
        else              mult = '0;
        pp = dig.neg ? ~mult : mult;   // one's complement, +1 goes via corrVec
      end

      // inverted sign on top; the constant vector removes the offset
      assign ppVec[i]   = ACC_W'({~pp[PPW-1], pp[PPW-2:0]}) << (2 * i);
      assign negBits[i] = dig.neg;

      // arithmetic digit value straight from the three multiplier bits
      assign digVal = -2 * int'(mplierExt[2*i+2]) + int'(mplierExt[2*i+1])
                      + int'(mplierExt[2*i]);

      // R5: inverted multiple plus its correction equals digit times multiplicand
      p_booth_pp_r5: assert property (@(posedge clk) disable iff (rst)
        int'($signed(pp)) + int'(dig.neg) == digVal * int'($signed(mcand)));
    end
  endgenerate

  always_comb begin
    corrVec = '0;
    for (int k = 0; k < NPP; k++) corrVec[2*k] = negBits[k];
  end
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree
  import mac_pkg::*;
#(
  parameter int N_OPS = 13,
  parameter int W     = 40
) (
  input  logic [N_OPS-1:0][W-1:0] ops,
  output logic [W-1:0]            sumVec,
  output logic [W-1:0]            carryVec
);
  localparam int LEVELS = treeLevels(N_OPS);

  always_comb begin
    logic [W-1:0] cur [N_OPS];
    logic [W-1:0] nxt [N_OPS];
    int n;
    int m;
    for (int k = 0; k < N_OPS; k++) cur[k] = ops[k];
    n = N_OPS;
    for (int lv = 0; lv < LEVELS; lv++) begin
      m = 0;
      for (int k = 0; k < N_OPS; k++) nxt[k] = '0;
      for (int k = 0; k < N_OPS; k += 3) begin
        if (k + 2 < n) begin
          nxt[m]   = cur[k] ^ cur[k+1] ^ cur[k+2];
          nxt[m+1] = ((cur[k] & cur[k+1]) | (cur[k] & cur[k+2])
                     | (cur[k+1] & cur[k+2])) << 1;
          m += 2;
        end else if (k < n) begin
          nxt[m] = cur[k];
          m++;
          if (k + 1 < n) begin
            nxt[m] = cur[k+1];
            m++;
          end
        end
      end
      for (int k = 0; k < N_OPS; k++) cur[k] = nxt[k];
      n = m;
    end
    sumVec   = cur[0];
    carryVec = cur[1];
  end
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clear,
  input  logic        validIn,
  output mac_strobe_t strobe
);
  always_comb begin
    strobe.zero = clear;
    strobe.load = validIn && !clear;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int LOW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  mac_strobe_t       strobe,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [ACC_W-1:0]  accOut
);
  localparam int NPP   = OP_W / 2;
  localparam int PPW   = OP_W + 1;
  localparam int N_OPS = NPP + 5;
  localparam int NCLA  = LOW_W / 2;
  localparam int UPW   = ACC_W - LOW_W;

  // sum of the -2^(top) offsets left by the inverted-sign trick
  function automatic logic [ACC_W-1:0] signExtConst();
    logic [ACC_W-1:0] k;
    k = '0;
    for (int i = 0; i < NPP; i++) k = k - (ACC_W'(1) << (PPW - 1 + 2 * i));
    return k;
  endfunction
  localparam logic [ACC_W-1:0] SIGN_K = signExtConst();

  logic [NPP-1:0][ACC_W-1:0]   ppVec;
  logic [ACC_W-1:0]            corrVec;
  logic [N_OPS-1:0][ACC_W-1:0] treeOps;
  logic [ACC_W-1:0]            treeSum;
  logic [ACC_W-1:0]            treeCarry;
  logic [LOW_W-1:0]            lowRes;
  logic [NCLA:0]               claC;

  logic [ACC_W-1:0]            sumQ;     // low LOW_W bits already resolved
  logic [UPW-1:0]              carryQ;   // upper carry vector only
  logic                        lowCoutQ; // carry out of the resolved field
  logic [UPW-1:0]              upperSum;

  mac_booth_pp #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pp (
    .clk     (clk),
    .rst     (rst),
    .mcand   (opA),
    .mplier  (opB),
    .ppVec   (ppVec),
    .corrVec (corrVec)
  );

  always_comb begin
    for (int k = 0; k < NPP; k++) treeOps[k] = ppVec[k];
    treeOps[NPP]     = SIGN_K;
    treeOps[NPP + 1] = corrVec;
    treeOps[NPP + 2] = sumQ;
    treeOps[NPP + 3] = {carryQ, {LOW_W{1'b0}}};
    treeOps[NPP + 4] = ACC_W'(lowCoutQ) << LOW_W;
  end

  mac_csa_tree #(.N_OPS(N_OPS), .W(ACC_W)) u_tree (
    .ops      (treeOps),
    .sumVec   (treeSum),
    .carryVec (treeCarry)
  );

  assign claC[0] = 1'b0;
  genvar j;
  generate
    for (j = 0; j < NCLA; j++) begin : g_cla
      mac_cla2 u_cla (
        .a    (treeSum[2*j+1 -: 2]),
        .b    (treeCarry[2*j+1 -: 2]),
        .cin  (claC[j]),
        .sum  (lowRes[2*j+1 -: 2]),
        .cout (claC[j+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || strobe.zero) begin
      sumQ     <= '0;
      carryQ   <= '0;
      lowCoutQ <= 1'b0;
    end else if (strobe.load) begin
      sumQ     <= {treeSum[ACC_W-1:LOW_W], lowRes};
      carryQ   <= treeCarry[ACC_W-1:LOW_W];
      lowCoutQ <= claC[NCLA];
    end
  end

  // narrow final adder: upper bits only
  assign upperSum = sumQ[ACC_W-1:LOW_W] + carryQ + UPW'(lowCoutQ);
  assign accOut   = {upperSum, sumQ[LOW_W-1:0]};

  // checker-side reference totals
  logic [ACC_W-1:0] opsTotal;
  always_comb begin
    opsTotal = '0;
    for (int k = 0; k < N_OPS; k++) opsTotal = opsTotal + treeOps[k];
  end

  // R1: the carry-save tree keeps the modular sum of all its inputs
  p_tree_sum_r1: assert property (@(posedge clk) disable iff (rst)
    treeSum + treeCarry == opsTotal);

  // R7: lookahead chain matches a plain add of the low columns
  p_low_cla_r7: assert property (@(posedge clk) disable iff (rst)
    {claC[NCLA], lowRes} == (LOW_W + 1)'(treeSum[LOW_W-1:0])
                            + (LOW_W + 1)'(treeCarry[LOW_W-1:0]));
endmodule

// File: rtl/booth_csa_mac.sv
module booth_csa_mac
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int LOW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              validIn,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [ACC_W-1:0]  accOut
);
  mac_strobe_t strobe;

  mac_ctrl u_ctrl (
    .clear   (clear),
    .validIn (validIn),
    .strobe  (strobe)
  );

  mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W), .LOW_W(LOW_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .accOut (accOut)
  );

  // reference product for the port-level checks
  logic signed [ACC_W-1:0] extA;
  logic signed [ACC_W-1:0] extB;
  logic [ACC_W-1:0]        prodRef;
  assign extA    = ACC_W'($signed(opA));
  assign extB    = ACC_W'($signed(opB));
  assign prodRef = extA * extB;

  // R1 / R6: total advances by the signed product, modulo 2^ACC_W
  p_accum_r1: assert property (@(posedge clk) disable iff (rst)
    (validIn && !clear) |=> accOut == $past(accOut) + $past(prodRef));

  // R2: idle cycles leave the total untouched
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!validIn && !clear) |=> $stable(accOut));

  // R3: clear empties the total
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clear |=> accOut == '0);

  // R4: synchronous reset empties the total
  p_reset_r4: assert property (@(posedge clk)
    rst |=> accOut == '0);
endmodule

// File: tb/sim_booth_csa_mac.sv
module sim_booth_csa_mac;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W  = 16;
  localparam int ACC_W = 40;

  typedef struct {
    logic [ACC_W-1:0] exp;
    string            tag;
  } sb_item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clear = 1'b0;
  logic             validIn = 1'b0;
  logic [OP_W-1:0]  opA = '0;
  logic [OP_W-1:0]  opB = '0;
  logic [ACC_W-1:0] accOut;

  logic [ACC_W-1:0] model = '0;
  sb_item_t         sbq[$];
  int               nChecks = 0;
  int               nFail = 0;
  bit               done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  booth_csa_mac u0 (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .validIn (validIn),
    .opA     (opA),
    .opB     (opB),
    .accOut  (accOut)
  );

  function automatic logic [ACC_W-1:0] sprod(input logic [OP_W-1:0] a,
                                             input logic [OP_W-1:0] b);
    logic signed [ACC_W-1:0] ea;
    logic signed [ACC_W-1:0] eb;
    ea = ACC_W'($signed(a));
    eb = ACC_W'($signed(b));
    return ea * eb;
  endfunction

  // driver: one clock per call, pushes the expected total
  task automatic drive(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                       input logic v, input logic c, input logic r,
                       input string tag);
    sb_item_t it;
    opA = a; opB = b; validIn = v; clear = c; rst = r;
    @(posedge clk);
    if (r || c) model = '0;
    else if (v) model = model + sprod(a, b);
    it.exp = model;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      nChecks++;
      if (accOut !== it.exp) begin
        nFail++;
        $display("FAIL %s: accOut=%h expected=%h", it.tag, accOut, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R4: reset state
    drive(16'h1234, 16'h5678, 1'b1, 1'b0, 1'b1, "R4");
    // R5: corner operands covering digit codes
    drive(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0, "R5");   // +2^30
    drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R5");   // +1
    drive(16'h0000, 16'h3039, 1'b1, 1'b0, 1'b0, "R5");   // +0
    drive(16'h7FFF, 16'hAAAA, 1'b1, 1'b0, 1'b0, "R5");
    drive(16'h8000, 16'h5555, 1'b1, 1'b0, 1'b0, "R5");
    // R2: hold with operands present
    drive(16'h007B, 16'h01C8, 1'b0, 1'b0, 1'b0, "R2");
    drive(16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b0, "R2");
    // R3: clear beats valid
    drive(16'h0007, 16'h0007, 1'b1, 1'b1, 1'b0, "R3");
    // R8: negative product sign-extended
    drive(16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b0, "R8");
    drive(16'h8000, 16'h7FFF, 1'b1, 1'b0, 1'b0, "R8");
    // R7: carry out of the resolved low field
    drive(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, "R3");
    drive(16'h00FF, 16'h0001, 1'b1, 1'b0, 1'b0, "R7");
    drive(16'h0001, 16'h0001, 1'b1, 1'b0, 1'b0, "R7");
    drive(16'h00FF, 16'h00FF, 1'b1, 1'b0, 1'b0, "R7");
    drive(16'hFF01, 16'h0001, 1'b1, 1'b0, 1'b0, "R7");
    // R6: wrap past 2^39 and 2^40
    drive(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, "R3");
    for (int k = 0; k < 1100; k++)
      drive(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0, "R6");
    for (int k = 0; k < 300; k++)
      drive(16'h8000, 16'h7FFF, 1'b1, 1'b0, 1'b0, "R6");
    // R1: random stream with holds and occasional clears
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      drive(16'($urandom), 16'($urandom), rv[3:0] != 4'd0,
            rv[9:4] == 6'd0, 1'b0, "R1");
    end
    // R4: reset in mid-run overrides valid
    drive(16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, "R4");
    drive(16'h1111, 16'h2222, 1'b1, 1'b0, 1'b0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule